// File: doc/BRIEF.md
# Receive FIFO with Trigger-Level Interrupt

This block buffers characters coming out of a serial receiver's shift register and turns its fill state into host-facing status. Each push strobe stores one character. Each pop strobe, produced when the host reads the holding register, removes the oldest character. The oldest character is always visible on the read-data output.

Two pieces of status come from the fill count. The data-ready flag depends only on whether the buffer holds anything. The receive interrupt compares the fill count with a threshold chosen by a 2-bit select. Neither is latched: both follow the count in the cycle after it changes. An interrupt-source code tells the host whether the receive interrupt is active.

When buffering is disabled, the block holds a single character, and the interrupt then follows the data-ready flag. Toggling the enable empties the buffer.

Top module: `rx_trig_fifo`

## Requirements
- R1: After a synchronous active-low reset, the level is 0, data-ready is 0, the interrupt is 0 and the source code is 4'b0001.
- R2: Characters leave in the order they were accepted, and the read-data output always shows the oldest stored character.
- R3: Data-ready is 1 in the cycle after a character is accepted into an empty buffer, whatever the threshold, and it returns to 0 once the level reaches 0.
- R4: With buffering and the interrupt enabled, the interrupt is 1 while the level is at or above the threshold and 0 while it is below. Select value 0 gives a threshold of 1, 1 gives 8, 2 gives 16 and 3 gives 56.
- R5: The source code is 4'b0100 while the interrupt is active and 4'b0001 ("no interrupt") otherwise.
- R6: With the receive interrupt enable at 0, the interrupt stays 0 and the code reads 4'b0001, while data-ready still follows the level.
- R7: With buffering disabled, capacity is one character, and the interrupt equals data-ready gated by the interrupt enable, regardless of the select.
- R8: A push that finds the buffer full and is not paired with a pop is dropped. The level and contents are left unchanged, and the overrun output pulses high for exactly one cycle.
- R9: A push and a pop in the same cycle on a non-empty buffer leave the level unchanged.
- R10: A pop on an empty buffer is ignored, and the level stays 0.
- R11: A change of the buffering enable empties the buffer in the following cycle and discards any push or pop presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Store a character from the receive shifter |
| push_data_i | input | 8 | Character to store |
| pop_i | input | 1 | Host read of the holding register |
| fifo_en_i | input | 1 | 1 = 64-deep buffering, 0 = single holding register |
| trig_sel_i | input | 2 | Threshold select (0:1, 1:8, 2:16, 3:56) |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| rd_data_o | output | 8 | Oldest stored character |
| level_o | output | 7 | Number of stored characters |
| data_ready_o | output | 1 | At least one character stored |
| irq_o | output | 1 | Receive-data-available interrupt |
| src_code_o | output | 4 | Interrupt source code |
| overrun_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
The level is registered. Level, data-ready, interrupt and source code are therefore all due one clock after the edge that accepts a push or pop, and the overrun pulse is due one clock after the dropped push. The bench drives strobes on the falling edge, so every such result is sampled at the next falling edge. Read data, by contrast, shows the head before the pop takes effect. The scoreboard monitor therefore compares it shortly after the falling edge at which the pop is presented, against the front of the queue of characters the driver predicted would be accepted.

// File: rtl/rxq_pkg.sv
// Shared types and helpers for the receive FIFO block.
// Assumes the depth is a power of two and at least 16.
package rxq_pkg;
    typedef enum logic [3:0] {
        SRC_NONE = 4'b0001,
        SRC_RDA  = 4'b0100
    } src_code_e;

    // Threshold for a select value, scaled from the buffer depth.
    function automatic int unsigned trig_thr(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 8;
            2'd2:    return depth / 4;
            default: return depth - 8;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Circular character store with a fill counter and an overrun pulse.
// Assumes cap_i <= DEPTH. A flush clears the pointers and the level and
// ignores strobes in that cycle.
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [LW-1:0] cap_i,
    output logic [DW-1:0] dout_o,
    output logic [LW-1:0] level_o,
    output logic          overrun_o
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q;
    logic          pop_ok, push_ok, overrun_q;

    // Decide which strobes take effect this cycle.
    always_comb begin
        pop_ok  = pop_i && (level_q != '0) && !flush_i;
        push_ok = push_i && !flush_i && ((level_q < cap_i) || pop_ok);
    end

    // Write accepted characters into the array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din_i;
    end

    // Advance the pointers and the level; register the overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            level_q   <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level_q   <= level_q + LW'(push_ok) - LW'(pop_ok);
            overrun_q <= push_i && !push_ok;
        end
    end

    assign dout_o    = mem[rd_ptr];
    assign level_o   = level_q;
    assign overrun_o = overrun_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH));
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && level_q == cap_i)
        |=> (overrun_o && level_q == $past(level_q)));
    // R9
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && level_q != '0)
        |=> level_q == $past(level_q));
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && level_q == '0) |=> level_q == '0);
endmodule

// File: rtl/rxq_trigger.sv
// Compares the fill level with the selected threshold and forms the
// interrupt and its source code. Purely combinational; not latched.
module rxq_trigger #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LW-1:0]        level_i,
    input  logic [1:0]           sel_i,
    input  logic                 fifo_en_i,
    input  logic                 irq_en_i,
    output logic                 irq_o,
    output rxq_pkg::src_code_e   code_o
);
    logic [LW-1:0] thr;
    logic          hit;

    // Pick the threshold; with buffering off any stored character counts.
    always_comb begin
        thr   = LW'(rxq_pkg::trig_thr(sel_i, DEPTH));
        hit   = fifo_en_i ? (level_i >= thr) : (level_i != '0);
        irq_o = irq_en_i && hit;
    end

    // Report the source code matching the interrupt state.
    always_comb begin
        code_o = irq_o ? rxq_pkg::SRC_RDA : rxq_pkg::SRC_NONE;
    end

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);
    // R4
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (level_i != '0));
endmodule

// File: rtl/rx_trig_fifo.sv
// Top of the receive FIFO: store, trigger comparison, enable-change flush.
// Assumes push and pop are single-cycle strobes in the clk domain.
module rx_trig_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic          fifo_en_i,
    input  logic [1:0]    trig_sel_i,
    input  logic          rx_irq_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic [LW-1:0] level_o,
    output logic          data_ready_o,
    output logic          irq_o,
    output logic [3:0]    src_code_o,
    output logic          overrun_o
);
    logic               en_q, flush;
    logic [LW-1:0]      cap;
    rxq_pkg::src_code_e code;

    // Remember the enable so a change can trigger a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= fifo_en_i;
    end

    // Flush on enable change; choose capacity from the mode.
    always_comb begin
        flush = (fifo_en_i != en_q);
        cap   = fifo_en_i ? LW'(DEPTH) : LW'(1);
    end

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .din_i(push_data_i),
        .pop_i(pop_i), .flush_i(flush), .cap_i(cap), .dout_o(rd_data_o),
        .level_o(level_o), .overrun_o(overrun_o)
    );

    rxq_trigger #(.DEPTH(DEPTH)) u_trig (
        .clk(clk), .rst_n(rst_n), .level_i(level_o), .sel_i(trig_sel_i),
        .fifo_en_i(fifo_en_i), .irq_en_i(rx_irq_en_i), .irq_o(irq_o),
        .code_o(code)
    );

    assign src_code_o   = code;
    assign data_ready_o = (level_o != '0);

    // R3
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush && level_o == '0) |=> data_ready_o);
    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_o == '0));
    // R7
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && !flush) |-> (level_o <= LW'(1)));
endmodule

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0, pop_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       fifo_en_i = 1'b1, rx_irq_en_i = 1'b1;
    logic [1:0] trig_sel_i = 2'd0;
    logic [7:0] rd_data_o;
    logic [6:0] level_o;
    logic       data_ready_o, irq_o, overrun_o;
    logic [3:0] src_code_o;

    int checks = 0, failures = 0;
    int mdl_lvl = 0;
    bit done = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    rx_trig_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .fifo_en_i(fifo_en_i), .trig_sel_i(trig_sel_i),
        .rx_irq_en_i(rx_irq_en_i), .rd_data_o(rd_data_o), .level_o(level_o),
        .data_ready_o(data_ready_o), .irq_o(irq_o), .src_code_o(src_code_o),
        .overrun_o(overrun_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one strobe cycle, then idle; predicts what the design accepts.
    task automatic op(input bit p, input logic [7:0] d, input bit q);
        int cap = fifo_en_i ? 64 : 1;
        bit pop_ok  = q && mdl_lvl != 0;
        bit push_ok = p && (mdl_lvl < cap || pop_ok);
        @(negedge clk);
        push_i = p; push_data_i = d; pop_i = q;
        if (push_ok) exp_q.push_back(d);
        mdl_lvl = mdl_lvl + int'(push_ok) - int'(pop_ok);
        @(negedge clk);
        push_i = 0; pop_i = 0;
    endtask

    // Monitor: compare the head with the scoreboard while a pop is presented.
    always @(negedge clk) begin
        #1;
        if (rst_n && pop_i && exp_q.size() > 0) begin
            check("R2 head", int'(rd_data_o), int'(exp_q[0]));
            void'(exp_q.pop_front());
        end
    end

    task automatic set_en(input bit e);
        @(negedge clk);
        fifo_en_i = e;
        @(negedge clk);
        mdl_lvl = 0;
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 level", int'(level_o), 0);
        check("R1 ready", int'(data_ready_o), 0);
        check("R1 irq", int'(irq_o), 0);
        check("R1 code", int'(src_code_o), 4'b0001);

        op(1, 8'hA1, 0);
        check("R3 ready after push", int'(data_ready_o), 1);
        check("R4 irq thr1", int'(irq_o), 1);
        check("R5 code rda", int'(src_code_o), 4'b0100);
        op(0, 0, 1);
        check("R3 ready clears", int'(data_ready_o), 0);
        check("R5 code none", int'(src_code_o), 4'b0001);

        trig_sel_i = 2'd1;
        for (int i = 0; i < 7; i++) op(1, 8'(8'h10 + i), 0);
        check("R4 below 8", int'(irq_o), 0);
        check("R3 ready independent of trigger", int'(data_ready_o), 1);
        op(1, 8'h17, 0);
        check("R4 at 8", int'(irq_o), 1);
        rx_irq_en_i = 1'b0;
        @(negedge clk);
        check("R6 irq masked", int'(irq_o), 0);
        check("R6 code none", int'(src_code_o), 4'b0001);
        rx_irq_en_i = 1'b1;
        op(0, 0, 1);
        check("R4 below after pop", int'(irq_o), 0);
        check("R4 level 7", int'(level_o), 7);
        trig_sel_i = 2'd2;
        for (int i = 0; i < 9; i++) op(1, 8'(8'h20 + i), 0);
        check("R4 at 16", int'(irq_o), 1);

        trig_sel_i = 2'd3;
        for (int i = 0; i < 39; i++) op(1, 8'(8'h40 + i), 0);
        check("R4 at 55", int'(irq_o), 0);
        op(1, 8'h90, 0);
        check("R4 at 56", int'(irq_o), 1);
        for (int i = 0; i < 8; i++) op(1, 8'(8'hB0 + i), 0);
        check("R8 full level", int'(level_o), 64);
        @(negedge clk);
        push_i = 1; push_data_i = 8'hEE;
        @(negedge clk);
        push_i = 0;
        check("R8 overrun pulse", int'(overrun_o), 1);
        check("R8 level kept", int'(level_o), 64);
        @(negedge clk);
        check("R8 pulse one cycle", int'(overrun_o), 0);
        op(1, 8'hC3, 1);
        check("R9 full push+pop", int'(level_o), 64);
        op(1, 8'hC4, 1);
        check("R9 push+pop level", int'(level_o), 64);
        while (mdl_lvl > 0) op(0, 0, 1);
        check("R3 empty", int'(data_ready_o), 0);
        check("R2 queue drained", exp_q.size(), 0);
        op(0, 0, 1);
        check("R10 pop empty", int'(level_o), 0);

        op(1, 8'h55, 0);
        op(1, 8'h56, 0);
        set_en(1'b0);
        check("R11 flush", int'(level_o), 0);
        op(1, 8'h61, 0);
        check("R7 irq follows ready", int'(irq_o), 1);
        op(1, 8'h62, 0);
        check("R7 single capacity", int'(level_o), 1);
        check("R7 overrun", int'(overrun_o), 1);
        op(0, 0, 1);
        check("R7 empty", int'(irq_o), 0);
        set_en(1'b1);
        check("R11 flush back", int'(level_o), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule